// File: doc/BRIEF.md
# 24-bit Colour Byte-Lane Rotator

This block feeds a rectangle-fill engine with the foreground colour, background colour and write mask that apply to the pixel being drawn. It is needed when a 24-bit packed colour has to be written as three consecutive 8-bit pixels. The fill engine loads the three 32-bit words while the block is idle and raises a start pulse. After that it gives one step strobe per pixel, together with the count of pixels still to draw.

The block has two ways of serialising the colour. When the last-pixel, X-direction, Y-direction and 24-bit-rotate flags are all set, it picks one byte of each colour from the remaining count taken modulo 3. The picked byte is zero-extended, and the stored words stay as they are. Otherwise, when the pixel depth code says 24 bits, each stored word is rotated right by one byte inside its low 24 bits after every pixel. At any other depth the words pass through unchanged.

Top module: `byte_lane_rotator`

## Requirements
- R1: After reset the busy output is 0 and the foreground, background and mask outputs are all 0.
- R2: A load pulse while idle captures the three input words. From the next cycle they appear unchanged on the outputs whenever lane-select mode is off.
- R3: In depth code 5 (24 bits per pixel) with lane-select mode off, each step strobe while busy replaces every stored word v with ((v>>8)&0xFFFF)|(v<<16), truncated to 32 bits. The new value is visible in the cycle after the strobe.
- R4: Three R3 rotations bring the low 24 bits of each word back to their loaded value.
- R5: At any depth code other than 5 (1 to 4 = 4, 8, 15 and 16 bits, 6 = 32 bits), step strobes leave all outputs unchanged.
- R6: Lane-select mode is active when last-pixel, X-direction, Y-direction and rotate are all 1. The foreground and background outputs are then the byte chosen by the remaining count modulo 3, zero-extended: a remainder of 2 gives bits 7:0, 1 gives bits 15:8 and 0 gives bits 23:16. The mask output is the stored mask. Step strobes do not rotate.
- R7: If any one of the four flags is 0, lane-select mode is off and R3 rotation applies at depth code 5.
- R8: A step strobe while not busy has no effect on any output.
- R9: A load pulse while busy is ignored.
- R10: A start pulse while idle sets busy in the next cycle. A step strobe with a remaining count of 1 or less clears busy in the next cycle.
- R11: A load while idle after rotations restores the unrotated input words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture the colour and mask inputs (only while idle) |
| fg_i | input | 32 | Foreground colour to load |
| bg_i | input | 32 | Background colour to load |
| wmask_i | input | 32 | Write mask to load |
| depth_i | input | 3 | Pixel depth code, 5 = 24 bits |
| last_pel_i | input | 1 | Last-pixel flag |
| x_dir_i | input | 1 | X-direction flag |
| y_dir_i | input | 1 | Y-direction flag |
| rot24_i | input | 1 | 24-bit rotate flag |
| start_i | input | 1 | Begin an operation (only while idle) |
| step_i | input | 1 | One pixel processed |
| count_i | input | 15 | Pixels remaining, including the current one |
| fg_o | output | 32 | Foreground for the current pixel |
| bg_o | output | 32 | Background for the current pixel |
| wmask_o | output | 32 | Write mask for the current pixel |
| busy_o | output | 1 | Operation in progress |

## Verification
Loads, rotations and busy changes all take effect at the clock edge that samples the pulse. They are due one cycle later, while the lane-select byte follows the flags and the count with no delay. The bench drives every pulse for exactly one cycle, starting at a falling edge, and updates its own model of the stored words at the rising edge that samples the pulse. It compares the outputs just after the next falling edge, once the combinational lane selection has settled for the count and flags that are then applied.

// File: rtl/byte_lane_rotator_pkg.sv
package byte_lane_rotator_pkg;
   typedef enum logic [2:0] {
      PIX_NONE = 3'd0,
      PIX_4    = 3'd1,
      PIX_8    = 3'd2,
      PIX_15   = 3'd3,
      PIX_16   = 3'd4,
      PIX_24   = 3'd5,
      PIX_32   = 3'd6
   } pix_depth_e;

   typedef struct packed {
      logic last_pel;
      logic x_dir;
      logic y_dir;
      logic rot24;
   } walk_flags_t;

   localparam int NUM_WORDS = 3;
   localparam int W_FG = 0;
   localparam int W_BG = 1;
   localparam int W_MK = 2;
endpackage

// File: rtl/blr_mode_decode.sv
module blr_mode_decode
   import byte_lane_rotator_pkg::*;
(
   input  logic [2:0]  depth_i,
   input  walk_flags_t flags_i,
   output logic        lane_mode_o,
   output logic        rot_mode_o
);
   pix_depth_e depth;
   logic       is24;

   always_comb begin
      depth       = pix_depth_e'(depth_i);
      is24        = (depth == PIX_24);
      lane_mode_o = flags_i.last_pel & flags_i.x_dir & flags_i.y_dir & flags_i.rot24;
      rot_mode_o  = is24 & ~lane_mode_o;
   end
endmodule

// File: rtl/blr_word_reg.sv
module blr_word_reg #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   parameter int LANES  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_i,
   input  logic [DATA_W-1:0] ld_val_i,
   input  logic              rot_i,
   output logic [DATA_W-1:0] q_o
);
   localparam int KEEP_W = (LANES - 1) * LANE_W;
   localparam logic [DATA_W-1:0] KEEP_MASK = {DATA_W{1'b1}} >> (DATA_W - KEEP_W);

   logic [DATA_W-1:0] rot_val;

   always_comb begin
      rot_val = ((q_o >> LANE_W) & KEEP_MASK) | (q_o << KEEP_W);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         q_o <= '0;
      else if (ld_i)
         q_o <= ld_val_i;
      else if (rot_i)
         q_o <= rot_val;
   end
endmodule

// File: rtl/blr_lane_pick.sv
module blr_lane_pick #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   parameter int LANES  = 3,
   parameter int CNT_W  = 15
) (
   input  logic [DATA_W-1:0] word_i,
   input  logic [CNT_W-1:0]  count_i,
   output logic [DATA_W-1:0] lane_o
);
   logic [LANE_W-1:0] lanes [LANES];
   logic [CNT_W-1:0]  rem;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lanes[g] = word_i[g*LANE_W +: LANE_W];
   end

   assign rem = count_i % CNT_W'(LANES);

   always_comb begin
      lane_o = '0;
      for (int i = 0; i < LANES; i++) begin
         if (rem == CNT_W'(LANES - 1 - i))
            lane_o[LANE_W-1:0] = lanes[i];
      end
   end
endmodule

// File: rtl/byte_lane_rotator.sv
module byte_lane_rotator
   import byte_lane_rotator_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   parameter int LANES  = 3,
   parameter int CNT_W  = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] fg_i,
   input  logic [DATA_W-1:0] bg_i,
   input  logic [DATA_W-1:0] wmask_i,
   input  logic [2:0]        depth_i,
   input  logic              last_pel_i,
   input  logic              x_dir_i,
   input  logic              y_dir_i,
   input  logic              rot24_i,
   input  logic              start_i,
   input  logic              step_i,
   input  logic [CNT_W-1:0]  count_i,
   output logic [DATA_W-1:0] fg_o,
   output logic [DATA_W-1:0] bg_o,
   output logic [DATA_W-1:0] wmask_o,
   output logic              busy_o
);
   if (LANE_W < 1 || LANES < 2) begin : g_bad_lanes
      $error("byte_lane_rotator: need LANE_W >= 1 and LANES >= 2");
   end
   if (DATA_W < LANES * LANE_W) begin : g_bad_width
      $error("byte_lane_rotator: DATA_W must hold LANES*LANE_W bits");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("byte_lane_rotator: CNT_W must be at least 2");
   end

   walk_flags_t flags;
   logic        lane_mode;
   logic        rot_mode;
   logic        ld_en;
   logic        rot_en;
   logic        last_step;
   logic [NUM_WORDS-1:0][DATA_W-1:0] words_in;
   logic [NUM_WORDS-1:0][DATA_W-1:0] words_q;
   logic [1:0][DATA_W-1:0]           picked;

   assign flags = '{last_pel: last_pel_i, x_dir: x_dir_i, y_dir: y_dir_i, rot24: rot24_i};

   blr_mode_decode u_dec (
      .depth_i     (depth_i),
      .flags_i     (flags),
      .lane_mode_o (lane_mode),
      .rot_mode_o  (rot_mode)
   );

   assign ld_en     = load_i & ~busy_o;
   assign rot_en    = busy_o & step_i & rot_mode;
   assign last_step = busy_o & step_i & (count_i <= CNT_W'(1));

   assign words_in[W_FG] = fg_i;
   assign words_in[W_BG] = bg_i;
   assign words_in[W_MK] = wmask_i;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      blr_word_reg #(
         .DATA_W (DATA_W),
         .LANE_W (LANE_W),
         .LANES  (LANES)
      ) u_reg (
         .clk      (clk),
         .rst_n    (rst_n),
         .ld_i     (ld_en),
         .ld_val_i (words_in[w]),
         .rot_i    (rot_en),
         .q_o      (words_q[w])
      );
   end

   for (genvar c = 0; c < 2; c++) begin : g_pick
      blr_lane_pick #(
         .DATA_W (DATA_W),
         .LANE_W (LANE_W),
         .LANES  (LANES),
         .CNT_W  (CNT_W)
      ) u_pick (
         .word_i  (words_q[c]),
         .count_i (count_i),
         .lane_o  (picked[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         busy_o <= 1'b0;
      else if (!busy_o && start_i)
         busy_o <= 1'b1;
      else if (last_step)
         busy_o <= 1'b0;
   end

   always_comb begin
      fg_o    = lane_mode ? picked[W_FG] : words_q[W_FG];
      bg_o    = lane_mode ? picked[W_BG] : words_q[W_BG];
      wmask_o = words_q[W_MK];
   end
endmodule

// File: rtl/byte_lane_rotator_chk.sv
module byte_lane_rotator_chk #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   parameter int LANES  = 3,
   parameter int CNT_W  = 15
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   load_i,
   input logic                   step_i,
   input logic                   start_i,
   input logic [CNT_W-1:0]       count_i,
   input logic                   busy_o,
   input logic                   lane_mode,
   input logic                   rot_mode,
   input logic [DATA_W-1:0]      fg_o,
   input logic [DATA_W-1:0]      bg_o,
   input logic [2:0][DATA_W-1:0] words_q
);
   localparam int KEEP_W = (LANES - 1) * LANE_W;

   function automatic logic [DATA_W-1:0] rot_ref(input logic [DATA_W-1:0] v);
      logic [DATA_W-1:0] lo;
      lo = v >> LANE_W;
      for (int i = KEEP_W; i < DATA_W; i++) lo[i] = 1'b0;
      return lo | (v << KEEP_W);
   endfunction

   // R3: a rotating step moves every stored word by one lane
   a_r3_rotate_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && step_i && rot_mode) |=>
         (words_q[0] == rot_ref($past(words_q[0])) &&
          words_q[1] == rot_ref($past(words_q[1])) &&
          words_q[2] == rot_ref($past(words_q[2]))));

   // R5 and R8: without an idle load or a rotating step the words hold
   a_r5_hold_words: assert property (@(posedge clk) disable iff (!rst_n)
      (!(busy_o && step_i && rot_mode) && !(load_i && !busy_o)) |=> $stable(words_q));

   // R9: a load while busy with no step changes nothing
   a_r9_busy_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && load_i && !step_i) |=> $stable(words_q));

   // R6: lane-select output is one zero-extended byte
   a_r6_lane_zext: assert property (@(posedge clk) disable iff (!rst_n)
      lane_mode |-> ((fg_o >> LANE_W) == '0 && (bg_o >> LANE_W) == '0));

   // R10: the final step ends the operation
   a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && step_i && count_i <= CNT_W'(1)) |=> !busy_o);

   // R10: start from idle sets busy
   a_r10_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> busy_o);
endmodule

bind byte_lane_rotator byte_lane_rotator_chk #(
   .DATA_W (DATA_W),
   .LANE_W (LANE_W),
   .LANES  (LANES),
   .CNT_W  (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .load_i    (load_i),
   .step_i    (step_i),
   .start_i   (start_i),
   .count_i   (count_i),
   .busy_o    (busy_o),
   .lane_mode (lane_mode),
   .rot_mode  (rot_mode),
   .fg_o      (fg_o),
   .bg_o      (bg_o),
   .words_q   (words_q)
);

// File: tb/byte_lane_rotator_test.sv
`timescale 1ns/1ps
module byte_lane_rotator_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_i = 1'b0;
   logic [31:0] fg_i = '0, bg_i = '0, wmask_i = '0;
   logic [2:0]  depth_i = 3'd5;
   logic        last_pel_i = 1'b0, x_dir_i = 1'b0, y_dir_i = 1'b0, rot24_i = 1'b0;
   logic        start_i = 1'b0, step_i = 1'b0;
   logic [14:0] count_i = 15'd10;
   logic [31:0] fg_o, bg_o, wmask_o;
   logic        busy_o;

   int n_checks = 0;
   int n_fail = 0;
   logic [31:0] efg = '0, ebg = '0, emk = '0;
   logic        ebusy = 1'b0;

   always #5 clk = ~clk;

   byte_lane_rotator uut (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .fg_i(fg_i), .bg_i(bg_i),
      .wmask_i(wmask_i), .depth_i(depth_i), .last_pel_i(last_pel_i),
      .x_dir_i(x_dir_i), .y_dir_i(y_dir_i), .rot24_i(rot24_i),
      .start_i(start_i), .step_i(step_i), .count_i(count_i),
      .fg_o(fg_o), .bg_o(bg_o), .wmask_o(wmask_o), .busy_o(busy_o)
   );

   function automatic logic [31:0] rot(input logic [31:0] v);
      return ((v >> 8) & 32'h0000FFFF) | (v << 16);
   endfunction

   function automatic logic lane_on();
      return last_pel_i & x_dir_i & y_dir_i & rot24_i;
   endfunction

   function automatic logic [31:0] pick(input logic [31:0] v);
      int r;
      r = count_i % 3;
      if (r == 2) return {24'h0, v[7:0]};
      if (r == 1) return {24'h0, v[15:8]};
      return {24'h0, v[23:16]};
   endfunction

   // one cycle of pulses, entered and left at a falling edge
   task automatic tick(input logic ld, input logic st, input logic sp);
      load_i = ld; start_i = st; step_i = sp;
      @(posedge clk);
      if (ld && !ebusy) begin
         efg = fg_i; ebg = bg_i; emk = wmask_i;
      end else if (ebusy && sp && depth_i == 3'd5 && !lane_on()) begin
         efg = rot(efg); ebg = rot(ebg); emk = rot(emk);
      end
      if (!ebusy && st) ebusy = 1'b1;
      else if (ebusy && sp && count_i <= 15'd1) ebusy = 1'b0;
      @(negedge clk);
      load_i = 1'b0; start_i = 1'b0; step_i = 1'b0;
   endtask

   task automatic check_out(input string req);
      logic [31:0] xf, xb;
      #1;
      xf = lane_on() ? pick(efg) : efg;
      xb = lane_on() ? pick(ebg) : ebg;
      n_checks++;
      if (fg_o !== xf || bg_o !== xb || wmask_o !== emk) begin
         n_fail++;
         $display("FAIL %s: fg/bg/mask actual %h %h %h expected %h %h %h",
                  req, fg_o, bg_o, wmask_o, xf, xb, emk);
      end
   endtask

   task automatic check_busy(input string req);
      #1;
      n_checks++;
      if (busy_o !== ebusy) begin
         n_fail++;
         $display("FAIL %s: busy actual %b expected %b", req, busy_o, ebusy);
      end
   endtask

   task automatic set_cols(input logic [31:0] f, input logic [31:0] b, input logic [31:0] m);
      fg_i = f; bg_i = b; wmask_i = m;
   endtask

   task automatic t_reset();
      check_out("R1");
      check_busy("R1");
   endtask

   task automatic t_load();
      depth_i = 3'd5;
      set_cols(32'h11AABBCC, 32'h22DDEEFF, 32'h33123456);
      tick(1, 0, 0);
      check_out("R2");
      tick(0, 1, 0);
      check_busy("R10 start");
   endtask

   task automatic t_rotate();
      logic [31:0] f0;
      f0 = efg;
      count_i = 15'd10;
      for (int i = 0; i < 3; i++) begin
         tick(0, 0, 1);
         count_i = count_i - 15'd1;
         check_out("R3");
      end
      n_checks++;
      if (fg_o[23:0] !== f0[23:0]) begin
         n_fail++;
         $display("FAIL R4: low24 actual %h expected %h", fg_o[23:0], f0[23:0]);
      end
      tick(0, 0, 1);
      count_i = count_i - 15'd1;
      check_out("R3 fourth");
   endtask

   task automatic t_busy_load();
      set_cols(32'hDEADBEEF, 32'hCAFEF00D, 32'h0BADC0DE);
      tick(1, 0, 0);
      check_out("R9");
   endtask

   task automatic t_other_depth();
      depth_i = 3'd6;
      tick(0, 0, 1);
      count_i = count_i - 15'd1;
      check_out("R5 depth6");
      depth_i = 3'd2;
      tick(0, 0, 1);
      count_i = count_i - 15'd1;
      check_out("R5 depth2");
      depth_i = 3'd5;
   endtask

   task automatic t_lane();
      last_pel_i = 1; x_dir_i = 1; y_dir_i = 1; rot24_i = 1;
      count_i = 15'd9;
      check_out("R6 rem0");
      for (int i = 0; i < 3; i++) begin
         tick(0, 0, 1);
         count_i = count_i - 15'd1;
         check_out("R6 step");
      end
   endtask

   task automatic t_one_flag_off();
      rot24_i = 0;
      count_i = 15'd5;
      tick(0, 0, 1);
      check_out("R7 rot flag off");
      last_pel_i = 0; rot24_i = 1;
      tick(0, 0, 1);
      check_out("R7 last flag off");
      last_pel_i = 0; x_dir_i = 0; y_dir_i = 0; rot24_i = 0;
   endtask

   task automatic t_finish_idle();
      count_i = 15'd1;
      tick(0, 0, 1);
      check_busy("R10 done");
      check_out("R10 last rotate");
      count_i = 15'd4;
      tick(0, 0, 1);
      check_out("R8");
      set_cols(32'h11AABBCC, 32'h22DDEEFF, 32'h33123456);
      tick(1, 0, 0);
      check_out("R11");
      n_checks++;
      if (fg_o !== 32'h11AABBCC) begin
         n_fail++;
         $display("FAIL R11: fg actual %h expected %h", fg_o, 32'h11AABBCC);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_load();
      t_rotate();
      t_busy_load();
      t_other_depth();
      t_lane();
      t_one_flag_off();
      t_finish_idle();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #100000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule